// File: doc/BRIEF.md
# Lockable Watchdog Counter

This block watches over start-up and run-time software. A 16-bit counter begins counting as soon as reset is released and advances once every 2 or once every 128 clock cycles. Software must send a service strobe before the count wraps past its top value. A service loads the upper byte of the counter from a programmable reload byte and clears the lower byte. This sets the length of the next interval.

If the counter wraps, the block raises an internal reset request for one cycle and drives an active-low reset pin low for a fixed number of cycles. It also sets a sticky flag that records the watchdog as the cause of the reset. Until the end-of-initialisation strobe arrives, software may stop the counter or change the reload byte and the step rate. After that strobe, both paths stay closed until the next reset.

Two reset inputs are used. `porN` is the power-on reset and clears everything, including the cause flag and the pin pulse. `sysRstN` is any hardware reset, including one caused by the watchdog itself. It clears the counter and the configuration but leaves the cause flag and the pin pulse alone.

Top module: `lockwdg_top`

## Requirements
- R1: After reset the count is 0, `rstReq` is low, `rstOutN` is high, and the counter advances by one every 2 clock cycles without any further action.
- R2: With the slow select set by a configuration write, the counter advances by one every 128 clock cycles once a service restarts the step phase.
- R3: A service strobe makes the count equal to {reload byte, 8'h00} in the next cycle and restarts the step phase, so the next step comes 2 (or 128) cycles later.
- R4: A disable strobe given before end of initialisation freezes the count.
- R5: After the end-of-initialisation strobe, disable strobes and configuration writes have no effect: the count keeps advancing, and a service still loads the reload byte and step rate set before the lock.
- R6: A step taken while the count is 16'hFFFF pulses `rstReq` high for exactly one cycle and loads the count with {reload byte, 8'h00}.
- R7: On that overflow, `rstOutN` goes low for exactly 16 clock cycles.
- R8: Overflow sets `wdtCause`. The flag survives `sysRstN` and is cleared only by `porN`.
- R9: With default settings (reload 0, divide by 2), the first overflow after reset occurs on the 131072nd clock edge.
- R10: A configuration write changes only the stored reload byte and rate. The running count does not jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| sysRstN | input | 1 | Hardware reset, active low, asynchronous |
| svcStb | input | 1 | Service strobe, one cycle |
| disStb | input | 1 | Disable request, one cycle |
| einitStb | input | 1 | End-of-initialisation strobe, one cycle |
| cfgWr | input | 1 | Configuration write strobe |
| cfgReload | input | 8 | Reload byte carried by a configuration write |
| cfgSlow | input | 1 | 1 selects divide by 128, 0 selects divide by 2 |
| count | output | 16 | Current counter value |
| rstReq | output | 1 | Internal reset request, one-cycle pulse |
| rstOutN | output | 1 | Reset pin, active low |
| wdtCause | output | 1 | Sticky flag: watchdog caused the last reset |

## Verification
The assertions check on every cycle that:
- the count only holds or steps by one, except at a service or an overflow;
- a service clears the low byte;
- a reset request lasts one cycle, coincides with the pin going low and with the cause flag, and leaves a cleared low byte.

Only the bench scenarios can show:
- the exact step periods in each rate;
- the 16-cycle pin width;
- the full default interval;
- the lock that ignores later disable and configuration strobes;
- the flag's survival across a hardware reset.

// File: rtl/lockwdg_pkg.sv
package lockwdg_pkg;
  localparam int CNT_W = 16;
  localparam int REL_W = 8;
  localparam int PRE_W = 7;

  typedef struct packed {
    logic             run;
    logic             slow;
    logic             load;
    logic [REL_W-1:0] reloadByte;
  } wdgStb_t;
endpackage

// File: rtl/lockwdg_dp.sv
module lockwdg_dp
  import lockwdg_pkg::*;
(
  input  logic             clk,
  input  logic             sysRstN,
  input  wdgStb_t          stb,
  output logic             ovf,
  output logic [CNT_W-1:0] count
);
  localparam int LOW_W = CNT_W - REL_W;

  logic [PRE_W-1:0] pre;
  logic             tick;

  always_comb begin
    tick = stb.run && (stb.slow ? (&pre) : pre[0]);
    ovf  = tick && (&count);
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      pre   <= '0;
      count <= '0;
    end else if (stb.load) begin
      pre   <= '0;
      count <= {stb.reloadByte, {LOW_W{1'b0}}};
    end else if (stb.run) begin
      pre <= pre + 1'b1;
      if (tick) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/lockwdg_ctrl.sv
module lockwdg_ctrl
  import lockwdg_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             sysRstN,
  input  logic             svcStb,
  input  logic             disStb,
  input  logic             einitStb,
  input  logic             cfgWr,
  input  logic [REL_W-1:0] cfgReload,
  input  logic             cfgSlow,
  input  logic             ovf,
  output wdgStb_t          stb,
  output logic             rstReq,
  output logic             rstOutN,
  output logic             wdtCause
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic             locked;
  logic             enabled;
  logic             slowSel;
  logic [REL_W-1:0] reloadVal;
  logic [PW-1:0]    pulseCnt;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      locked    <= 1'b0;
      enabled   <= 1'b1;
      slowSel   <= 1'b0;
      reloadVal <= '0;
      rstReq    <= 1'b0;
    end else begin
      rstReq <= ovf;
      if (einitStb) locked <= 1'b1;
      if (disStb && !locked) enabled <= 1'b0;
      if (cfgWr && !locked) begin
        reloadVal <= cfgReload;
        slowSel   <= cfgSlow;
      end
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pulseCnt <= '0;
      wdtCause <= 1'b0;
    end else begin
      if (ovf) begin
        pulseCnt <= PW'(PULSE_LEN);
        wdtCause <= 1'b1;
      end else if (pulseCnt != '0) begin
        pulseCnt <= pulseCnt - 1'b1;
      end
    end
  end

  always_comb begin
    stb.run        = enabled;
    stb.slow       = slowSel;
    stb.load       = svcStb || ovf;
    stb.reloadByte = reloadVal;
    rstOutN        = (pulseCnt == '0);
  end
endmodule

// File: rtl/lockwdg_top.sv
module lockwdg_top
  import lockwdg_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             sysRstN,
  input  logic             svcStb,
  input  logic             disStb,
  input  logic             einitStb,
  input  logic             cfgWr,
  input  logic [REL_W-1:0] cfgReload,
  input  logic             cfgSlow,
  output logic [CNT_W-1:0] count,
  output logic             rstReq,
  output logic             rstOutN,
  output logic             wdtCause
);
  wdgStb_t ctlStb;
  logic    ovf;

  lockwdg_ctrl #(.PULSE_LEN(PULSE_LEN)) u_ctrl (
    .clk(clk), .porN(porN), .sysRstN(sysRstN),
    .svcStb(svcStb), .disStb(disStb), .einitStb(einitStb),
    .cfgWr(cfgWr), .cfgReload(cfgReload), .cfgSlow(cfgSlow),
    .ovf(ovf), .stb(ctlStb),
    .rstReq(rstReq), .rstOutN(rstOutN), .wdtCause(wdtCause)
  );

  lockwdg_dp u_dp (
    .clk(clk), .sysRstN(sysRstN), .stb(ctlStb),
    .ovf(ovf), .count(count)
  );
endmodule

// File: rtl/lockwdg_chk.sv
module lockwdg_chk
  import lockwdg_pkg::*;
(
  input logic             clk,
  input logic             porN,
  input logic             sysRstN,
  input logic             svcStb,
  input logic [CNT_W-1:0] count,
  input logic             rstReq,
  input logic             rstOutN,
  input logic             wdtCause
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!sysRstN || !porN)
    (!svcStb && count != '1) |=> (count == $past(count) || count == $past(count) + 1'b1)); // R1

  AST_SVC_LOAD: assert property (@(posedge clk) disable iff (!sysRstN || !porN)
    svcStb |=> (count[7:0] == 8'h00)); // R3

  AST_REQ_ONE: assert property (@(posedge clk) disable iff (!sysRstN || !porN)
    rstReq |=> !rstReq); // R6

  AST_REQ_RELOAD: assert property (@(posedge clk) disable iff (!sysRstN || !porN)
    rstReq |-> (count[7:0] == 8'h00)); // R6

  AST_PIN_LOW: assert property (@(posedge clk) disable iff (!sysRstN || !porN)
    rstReq |-> !rstOutN); // R7

  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!sysRstN || !porN)
    rstReq |-> wdtCause); // R8
endmodule

bind lockwdg_top lockwdg_chk u_chk (
  .clk(clk), .porN(porN), .sysRstN(sysRstN), .svcStb(svcStb),
  .count(count), .rstReq(rstReq), .rstOutN(rstOutN), .wdtCause(wdtCause)
);

// File: tb/lockwdg_top_bench.sv
module lockwdg_top_bench;
  logic        clk = 1'b0;
  logic        porN = 1'b0, sysRstN = 1'b0;
  logic        svcStb = 1'b0, disStb = 1'b0, einitStb = 1'b0, cfgWr = 1'b0;
  logic [7:0]  cfgReload = 8'h00;
  logic        cfgSlow = 1'b0;
  logic [15:0] count;
  logic        rstReq, rstOutN, wdtCause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lockwdg_top u_lockwdg_top (
    .clk(clk), .porN(porN), .sysRstN(sysRstN),
    .svcStb(svcStb), .disStb(disStb), .einitStb(einitStb),
    .cfgWr(cfgWr), .cfgReload(cfgReload), .cfgSlow(cfgSlow),
    .count(count), .rstReq(rstReq), .rstOutN(rstOutN), .wdtCause(wdtCause)
  );

  localparam int NV = 5;
  localparam logic [7:0]  V_REL  [NV] = '{8'h12, 8'hA0, 8'h00, 8'h7F, 8'hFE};
  localparam logic        V_SLOW [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int          V_WAIT [NV] = '{10, 7, 256, 300, 1};
  localparam logic [15:0] V_EXP  [NV] = '{16'h1205, 16'hA003, 16'h0002, 16'h7F02, 16'hFE00};

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(bit power);
    if (power) porN = 1'b0;
    sysRstN = 1'b0;
    step(2);
    porN = 1'b1;
    sysRstN = 1'b1;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    step();
    s = 1'b0;
  endtask

  task automatic cfg(logic [7:0] rel, logic slow);
    cfgReload = rel;
    cfgSlow = slow;
    pulse(cfgWr);
  endtask

  initial begin
    #1;
    doReset(1'b1);
    // R1 reset state and free run
    chk("R1 count", count, 16'h0000);
    chk("R1 rstReq", rstReq, 0);
    chk("R1 rstOutN", rstOutN, 1);
    chk("R8 cause after por", wdtCause, 0);
    step(10);
    chk("R1 runs", count, 16'h0005);

    // table of vectors: R2, R3
    for (int v = 0; v < NV; v++) begin
      doReset(1'b0);
      cfg(V_REL[v], V_SLOW[v]);
      pulse(svcStb);
      step(V_WAIT[v]);
      chk(V_SLOW[v] ? "R2 slow step" : "R3 service load", count, V_EXP[v]);
    end

    // R10: configuration write does not move the count
    doReset(1'b0);
    step(4);
    cfg(8'h33, 1'b0);
    chk("R10 no jump", count, 16'h0002);
    pulse(svcStb);
    chk("R10 new reload", count, 16'h3300);

    // R4 disable before init
    doReset(1'b0);
    step(6);
    pulse(disStb);
    step(20);
    chk("R4 frozen", count, 16'h0003);

    // R5 lock ignores disable and config
    doReset(1'b0);
    cfg(8'h40, 1'b0);
    pulse(einitStb);
    pulse(disStb);
    cfg(8'h22, 1'b1);
    pulse(svcStb);
    chk("R5 old reload", count, 16'h4000);
    step(10);
    chk("R5 still running fast", count, 16'h4005);

    // R6 R7 R8 fast overflow
    doReset(1'b0);
    cfg(8'hFF, 1'b0);
    pulse(svcStb);
    step(511);
    chk("R6 before ovf", count, 16'hFFFF);
    chk("R6 no req yet", rstReq, 0);
    step();
    chk("R6 req", rstReq, 1);
    chk("R6 reload", count, 16'hFF00);
    chk("R7 pin low", rstOutN, 0);
    chk("R8 cause set", wdtCause, 1);
    step();
    chk("R6 one cycle", rstReq, 0);
    step(14);
    chk("R7 still low", rstOutN, 0);
    step();
    chk("R7 released", rstOutN, 1);
    doReset(1'b0);
    chk("R8 survives sysRst", wdtCause, 1);
    doReset(1'b1);
    chk("R8 cleared by por", wdtCause, 0);

    // R9 default full interval
    step(131071);
    chk("R9 top value", count, 16'hFFFF);
    chk("R9 no early req", rstReq, 0);
    step();
    chk("R9 req", rstReq, 1);
    chk("R9 wrap", count, 16'h0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule